// File: doc/BRIEF.md
# Display Self-Test Sequencer

This block runs the built-in test of an eight-digit dot-matrix display controller. A one-cycle start pulse, issued after a control-register write sets the self-test bit, launches a run of fixed length. The first part of the run reads every row of every glyph in the font ROM and adds the column data into a running 8-bit checksum. The checksum is then compared with an expected constant. The second part drives the display through an override frame: first a checkerboard, then the same checkerboard inverted. Each pattern is held for a fixed number of clocks.

When the run ends, the block issues one restore strobe into the register file. The strobe comes with the values to load: every character cell becomes the blank code, flash bits clear, glyph pointer all ones, and a control word that is zero except for the pass bit at position 5. A busy flag stays high from start to the end of the run, and the host interface uses it to refuse access. The run length, the pattern length, the font geometry, the ROM read latency and the expected checksum are all parameters.

Top module: `selftest_seq`

## Requirements
- R1: After reset, busy_o, ovr_en_o, rf_restore_o and pass_o are 0, ovr_frame_o is all zero, and rf_ctrl_o is 00h.
- R2: A start_i pulse sampled while idle makes busy_o high from the next cycle. busy_o then stays high for exactly RUN_CLKS cycles.
- R3: A start_i pulse sampled while busy_o is high has no effect. The run ends in the same cycle it would have ended without that pulse.
- R4: Call the cycle after the starting edge run cycle 0. In run cycle j, for j below GLYPHS*ROWS, the ROM address is rom_code_o = j / ROWS and rom_row_o = j mod ROWS. Rows advance fastest and codes ascend from 0.
- R5: The checksum is the modulo-256 sum of every column value, zero-extended, read over all rows of all codes. With a ROM read latency of ROM_LAT cycles, the data for an address appears ROM_LAT cycles after that address. If the checksum equals EXP_SUM, pass_o is 1 and bit 5 of rf_ctrl_o is 1 at the end of the run.
- R6: A checksum that differs from EXP_SUM leaves pass_o at 0 and bit 5 of rf_ctrl_o at 0.
- R7: While busy, ovr_en_o is 1. From run cycle 0 up to run cycle GLYPHS*ROWS+ROM_LAT-1, ovr_frame_o is all zero (dark).
- R8: For PAT_CLKS cycles from run cycle GLYPHS*ROWS+ROM_LAT, ovr_frame_o shows the checkerboard. Bit r*COLS+c (r is the row, c is the column) is 1 exactly when r+c is even.
- R9: For the next PAT_CLKS cycles, ovr_frame_o shows the inverse: bit r*COLS+c is 1 exactly when r+c is odd.
- R10: From the end of the inverse phase until the end of the run, ovr_frame_o is all zero.
- R11: In the single cycle after busy_o falls, rf_restore_o is 1, with rf_char_o = 20h, rf_flash_o = 00h, rf_glyph_o = 1111b, and rf_ctrl_o zero except bit 5. In every other cycle rf_restore_o is 0.
- R12: While idle, ovr_en_o is 0 and ovr_frame_o is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin the test |
| busy_o | output | 1 | High for the whole run; blocks host access |
| rom_code_o | output | 7 | Font ROM glyph code being read |
| rom_row_o | output | 3 | Font ROM row being read |
| rom_data_i | input | COLS (5) | Column bits returned by the font ROM |
| ovr_en_o | output | 1 | Display override active |
| ovr_frame_o | output | ROWS*COLS (35) | Override dot frame, bit r*COLS+c |
| rf_restore_o | output | 1 | One-cycle register-file restore strobe |
| rf_ctrl_o | output | 8 | Control word to load (bit 5 = pass) |
| rf_char_o | output | 8 | Code to fill every character cell |
| rf_glyph_o | output | 4 | Glyph pointer value to load |
| rf_flash_o | output | DIGITS (8) | Flash bits to load |
| pass_o | output | 1 | Result of the most recent run |

## Verification
The bench checks the ROM address at the very first read, at the first row wrap and at the last read. An off-by-one sweep would shift these addresses, or leave some reads out of the checksum. It compares the frame in the last cycle of the checkerboard phase, the first cycle of the inverse phase and the first cycle of the dark tail. A decoder with a wrong boundary would show the wrong pattern in one of those single cycles. A second start pulse in the middle of a run must not move the end of the run; a design that restarted on it would keep busy high too long. A run with a single corrupted ROM word must report failure, which shows the comparison really depends on the data read.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'd0,
      MODE_DARK = 2'd1,
      MODE_CHK  = 2'd2,
      MODE_INV  = 2'd3
   } ovr_mode_e;

   localparam logic [7:0] BLANK_CODE = 8'h20;
   localparam int         SUMW       = 8;
   localparam int         PASS_BIT   = 5;
endpackage

// File: rtl/selftest_romsum.sv
module selftest_romsum #(
   parameter int GLYPHS  = 128,
   parameter int ROWS    = 7,
   parameter int COLS    = 5,
   parameter int ROM_LAT = 1,
   localparam int CODEW  = $clog2(GLYPHS),
   localparam int ROWW   = $clog2(ROWS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           go_i,
   output logic [CODEW-1:0]               rom_code_o,
   output logic [ROWW-1:0]                rom_row_o,
   input  logic [COLS-1:0]                rom_data_i,
   output logic [selftest_pkg::SUMW-1:0]  sum_o
);
   import selftest_pkg::*;

   logic             act_q;
   logic [CODEW-1:0] code_q;
   logic [ROWW-1:0]  row_q;
   logic [SUMW-1:0]  sum_q;
   logic             take;

   localparam logic [ROWW-1:0]  LAST_ROW  = ROWW'(ROWS - 1);
   localparam logic [CODEW-1:0] LAST_CODE = CODEW'(GLYPHS - 1);

   if (COLS > SUMW) begin : g_bad_cols
      $error("selftest_romsum: COLS must not exceed checksum width");
   end
   if (ROM_LAT != 0 && ROM_LAT != 1) begin : g_bad_lat
      $error("selftest_romsum: ROM_LAT must be 0 or 1");
   end

   // ROM read latency picks the data-valid source
   if (ROM_LAT == 0) begin : g_comb_rom
      assign take = act_q;
   end else begin : g_reg_rom
      logic vld_q;
      always_ff @(posedge clk) begin
         if (!rst_n) vld_q <= 1'b0;
         else        vld_q <= act_q;
      end
      assign take = vld_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         code_q <= '0;
         row_q  <= '0;
         sum_q  <= '0;
      end else if (go_i) begin
         act_q  <= 1'b1;
         code_q <= '0;
         row_q  <= '0;
         sum_q  <= '0;
      end else begin
         if (act_q) begin
            if (row_q == LAST_ROW) begin
               row_q <= '0;
               if (code_q == LAST_CODE) begin
                  code_q <= '0;
                  act_q  <= 1'b0;
               end else begin
                  code_q <= code_q + 1'b1;
               end
            end else begin
               row_q <= row_q + 1'b1;
            end
         end
         if (take) sum_q <= sum_q + SUMW'(rom_data_i);
      end
   end

   assign rom_code_o = code_q;
   assign rom_row_o  = row_q;
   assign sum_o      = sum_q;

   // R4
   property addr_walk_p;
      @(posedge clk) disable iff (!rst_n)
      (act_q && $past(act_q)) |->
         ((row_q == '0) ? ($past(row_q) == LAST_ROW && code_q == $past(code_q) + 1'b1)
                        : (row_q == $past(row_q) + 1'b1 && code_q == $past(code_q)));
   endproperty
   addr_walk_chk: assert property (addr_walk_p);

   // R4
   property addr_idle_p;
      @(posedge clk) disable iff (!rst_n)
      (!act_q && !go_i) |=> (!act_q || $past(go_i)) ;
   endproperty
   addr_idle_chk: assert property (addr_idle_p);
endmodule

// File: rtl/selftest_pattern.sv
module selftest_pattern #(
   parameter int ROWS     = 7,
   parameter int COLS     = 5,
   parameter int CW       = 18,
   parameter int SCAN_CYC = 897,
   parameter int PAT_CLKS = 114688,
   localparam int FRAMEW  = ROWS * COLS,
   localparam int INV_BEG = SCAN_CYC + PAT_CLKS,
   localparam int TAIL_BEG = SCAN_CYC + 2 * PAT_CLKS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy_i,
   input  logic [CW-1:0]     cnt_i,
   output logic              ovr_en_o,
   output logic [FRAMEW-1:0] ovr_frame_o
);
   import selftest_pkg::*;

   ovr_mode_e mode;

   always_comb begin
      if (!busy_i)                        mode = MODE_OFF;
      else if (cnt_i < CW'(SCAN_CYC))     mode = MODE_DARK;
      else if (cnt_i < CW'(INV_BEG))      mode = MODE_CHK;
      else if (cnt_i < CW'(TAIL_BEG))     mode = MODE_INV;
      else                                mode = MODE_DARK;
   end

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam bit EVEN = ((r + c) % 2) == 0;
         assign ovr_frame_o[r*COLS + c] =
            (mode == MODE_CHK) ? EVEN :
            (mode == MODE_INV) ? !EVEN : 1'b0;
      end
   end

   assign ovr_en_o = busy_i;

   // R12
   property idle_dark_p;
      @(posedge clk) disable iff (!rst_n)
      !busy_i |-> (ovr_frame_o == '0 && !ovr_en_o);
   endproperty
   idle_dark_chk: assert property (idle_dark_p);

   // R8
   property one_pattern_p;
      @(posedge clk) disable iff (!rst_n)
      $onehot0({mode == MODE_CHK, mode == MODE_INV});
   endproperty
   one_pattern_chk: assert property (one_pattern_p);

   // R9
   property inv_after_chk_p;
      @(posedge clk) disable iff (!rst_n)
      $rose(mode == MODE_INV) |-> $past(mode == MODE_CHK);
   endproperty
   inv_after_chk_chk: assert property (inv_after_chk_p);
endmodule

// File: rtl/selftest_seq.sv
module selftest_seq #(
   parameter int GLYPHS   = 128,
   parameter int ROWS     = 7,
   parameter int COLS     = 5,
   parameter int DIGITS   = 8,
   parameter int ROM_LAT  = 1,
   parameter int RUN_CLKS = 262144,
   parameter int PAT_CLKS = 114688,
   parameter logic [7:0] EXP_SUM = 8'h00,
   localparam int CODEW    = $clog2(GLYPHS),
   localparam int ROWW     = $clog2(ROWS),
   localparam int FRAMEW   = ROWS * COLS,
   localparam int CW       = $clog2(RUN_CLKS + 1),
   localparam int SCAN_CYC = GLYPHS * ROWS + ROM_LAT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              busy_o,
   output logic [CODEW-1:0]  rom_code_o,
   output logic [ROWW-1:0]   rom_row_o,
   input  logic [COLS-1:0]   rom_data_i,
   output logic              ovr_en_o,
   output logic [FRAMEW-1:0] ovr_frame_o,
   output logic              rf_restore_o,
   output logic [7:0]        rf_ctrl_o,
   output logic [7:0]        rf_char_o,
   output logic [3:0]        rf_glyph_o,
   output logic [DIGITS-1:0] rf_flash_o,
   output logic              pass_o
);
   import selftest_pkg::*;

   if (RUN_CLKS < SCAN_CYC + 2 * PAT_CLKS) begin : g_bad_len
      $error("selftest_seq: RUN_CLKS too short for scan and both patterns");
   end
   if (PAT_CLKS < 1) begin : g_bad_pat
      $error("selftest_seq: PAT_CLKS must be positive");
   end

   localparam logic [CW-1:0] LAST_CNT = CW'(RUN_CLKS - 1);

   logic            busy_q;
   logic [CW-1:0]   cnt_q;
   logic            restore_q;
   logic            pass_q;
   logic            go;
   logic [SUMW-1:0] sum;

   assign go = start_i && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         cnt_q     <= '0;
         restore_q <= 1'b0;
         pass_q    <= 1'b0;
      end else begin
         restore_q <= 1'b0;
         if (go) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
         end else if (busy_q) begin
            if (cnt_q == LAST_CNT) begin
               busy_q    <= 1'b0;
               cnt_q     <= '0;
               restore_q <= 1'b1;
               pass_q    <= (sum == EXP_SUM);
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   selftest_romsum #(
      .GLYPHS (GLYPHS),
      .ROWS   (ROWS),
      .COLS   (COLS),
      .ROM_LAT(ROM_LAT)
   ) u_sum (
      .clk       (clk),
      .rst_n     (rst_n),
      .go_i      (go),
      .rom_code_o(rom_code_o),
      .rom_row_o (rom_row_o),
      .rom_data_i(rom_data_i),
      .sum_o     (sum)
   );

   selftest_pattern #(
      .ROWS    (ROWS),
      .COLS    (COLS),
      .CW      (CW),
      .SCAN_CYC(SCAN_CYC),
      .PAT_CLKS(PAT_CLKS)
   ) u_pat (
      .clk        (clk),
      .rst_n      (rst_n),
      .busy_i     (busy_q),
      .cnt_i      (cnt_q),
      .ovr_en_o   (ovr_en_o),
      .ovr_frame_o(ovr_frame_o)
   );

   always_comb begin
      rf_ctrl_o           = 8'h00;
      rf_ctrl_o[PASS_BIT] = pass_q;
   end

   assign busy_o       = busy_q;
   assign rf_restore_o = restore_q;
   assign rf_char_o    = BLANK_CODE;
   assign rf_glyph_o   = 4'hF;
   assign rf_flash_o   = '0;
   assign pass_o       = pass_q;

   // R2
   property start_cause_p;
      @(posedge clk) disable iff (!rst_n)
      $rose(busy_q) |-> $past(start_i);
   endproperty
   start_cause_chk: assert property (start_cause_p);

   // R3
   property ignore_start_p;
      @(posedge clk) disable iff (!rst_n)
      (busy_q && start_i && cnt_q != LAST_CNT) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1);
   endproperty
   ignore_start_chk: assert property (ignore_start_p);

   // R11
   property restore_after_run_p;
      @(posedge clk) disable iff (!rst_n)
      restore_q |-> ($past(busy_q) && !busy_q);
   endproperty
   restore_after_run_chk: assert property (restore_after_run_p);

   // R11
   property restore_once_p;
      @(posedge clk) disable iff (!rst_n)
      restore_q |=> !restore_q;
   endproperty
   restore_once_chk: assert property (restore_once_p);
endmodule

// File: tb/selftest_seq_test.sv
module selftest_seq_test;
   localparam int GLYPHS = 128;
   localparam int ROWS   = 7;
   localparam int COLS   = 5;
   localparam int RUN    = 2400;
   localparam int PAT    = 600;
   localparam int NREAD  = GLYPHS * ROWS;
   localparam int SCANC  = NREAD + 1;
   localparam int FW     = ROWS * COLS;

   function automatic logic [4:0] font(int code, int row, bit bad);
      int v;
      v = code * 3 + row * 5 + (code >> 3);
      if (bad && code == 5 && row == 2) v = v + 1;
      return 5'(v);
   endfunction

   function automatic logic [7:0] good_sum();
      int s;
      s = 0;
      for (int c = 0; c < GLYPHS; c++)
         for (int r = 0; r < ROWS; r++)
            s = s + int'(font(c, r, 1'b0));
      return 8'(s);
   endfunction

   localparam logic [7:0] GOOD = good_sum();

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic corrupt = 1'b0;
   logic busy, ovr_en, restore, pass;
   logic [6:0] code;
   logic [2:0] row;
   logic [4:0] rom_q;
   logic [FW-1:0] frame;
   logic [7:0] ctrl, chr;
   logic [3:0] glyph;
   logic [7:0] flash;

   int checks = 0;
   int fails  = 0;
   int cur    = 0;
   bit done   = 0;

   always #2.5 clk = ~clk;

   always_ff @(posedge clk) rom_q <= font(int'(code), int'(row), corrupt);

   selftest_seq #(
      .RUN_CLKS(RUN), .PAT_CLKS(PAT), .EXP_SUM(GOOD)
   ) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy),
      .rom_code_o(code), .rom_row_o(row), .rom_data_i(rom_q),
      .ovr_en_o(ovr_en), .ovr_frame_o(frame), .rf_restore_o(restore),
      .rf_ctrl_o(ctrl), .rf_char_o(chr), .rf_glyph_o(glyph),
      .rf_flash_o(flash), .pass_o(pass)
   );

   function automatic logic [FW-1:0] frame_of(int kind);
      logic [FW-1:0] f;
      f = '0;
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++)
            if (kind == 1) f[r*COLS+c] = ((r + c) % 2) == 0;
            else if (kind == 2) f[r*COLS+c] = ((r + c) % 2) == 1;
      return f;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic go_to(int j);
      repeat (j - cur) @(posedge clk);
      @(negedge clk);
      cur = j;
   endtask

   task automatic kick();
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cur = 0;
   endtask

   task automatic t_reset();
      check("R1 busy", busy, 0);
      check("R1 ovr_en", ovr_en, 0);
      check("R1 restore", restore, 0);
      check("R1 pass", pass, 0);
      check("R1 frame", frame, 0);
      check("R1 ctrl", ctrl, 0);
   endtask

   task automatic t_full_run();
      corrupt = 1'b0;
      kick();
      check("R2 busy rises", busy, 1);
      check("R7 ovr_en", ovr_en, 1);
      check("R4 code@0", code, 0);
      check("R4 row@0", row, 0);
      check("R7 dark scan", frame, 0);
      go_to(7);
      check("R4 code@7", code, 1);
      check("R4 row@7", row, 0);
      go_to(20);
      check("R4 code@20", code, 2);
      check("R4 row@20", row, 6);
      go_to(NREAD - 1);
      check("R4 code last", code, 127);
      check("R4 row last", row, 6);
      go_to(SCANC - 1);
      check("R7 dark end", frame, 0);
      go_to(SCANC);
      check("R8 checker start", frame, frame_of(1));
      go_to(SCANC + PAT - 1);
      check("R8 checker end", frame, frame_of(1));
      go_to(SCANC + PAT);
      check("R9 inverse start", frame, frame_of(2));
      go_to(SCANC + 2 * PAT - 1);
      check("R9 inverse end", frame, frame_of(2));
      go_to(SCANC + 2 * PAT);
      check("R10 tail dark", frame, 0);
      go_to(RUN - 1);
      check("R2 busy last", busy, 1);
      check("R11 no early restore", restore, 0);
      go_to(RUN);
      check("R2 busy falls", busy, 0);
      check("R11 restore", restore, 1);
      check("R11 char", chr, 8'h20);
      check("R11 glyph", glyph, 4'hF);
      check("R11 flash", flash, 0);
      check("R5 ctrl pass", ctrl, 8'h20);
      check("R5 pass", pass, 1);
      go_to(RUN + 1);
      check("R11 single pulse", restore, 0);
      check("R12 idle ovr", ovr_en, 0);
      check("R12 idle frame", frame, 0);
   endtask

   task automatic t_ignore_start();
      corrupt = 1'b0;
      kick();
      go_to(100);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cur = 101;
      go_to(RUN - 1);
      check("R3 busy kept", busy, 1);
      go_to(RUN);
      check("R3 end unchanged", busy, 0);
      check("R3 restore on time", restore, 1);
   endtask

   task automatic t_fail_run();
      corrupt = 1'b1;
      kick();
      go_to(RUN);
      check("R6 restore", restore, 1);
      check("R6 ctrl bit5", ctrl, 8'h00);
      check("R6 pass", pass, 0);
      corrupt = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_full_run();
      t_ignore_start();
      t_fail_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule